// File: doc/BRIEF.md
# Streaming Allocation/Release Pairing Checker

This block watches a stream of memory-management events from a trace pipeline and checks, at line rate, that every release of an address is paired with an earlier reservation of that same address. Each event carries a one-bit opcode (reserve or release) and an address. For every distinct address it tracks, the block keeps its own small two-state automaton (live or released) in a fixed-capacity table. A new address takes a table slot when it is reserved. A release moves the slot to a released state. A released slot stays in the table so that a repeated release can still be recognised, and it can be taken back when the table has no empty slot left.

Faults are reported on a registered violation port as a code and the offending address. A violation is held for exactly one cycle for each event that caused it. When the trace ends, a strobe starts a sweep. The sweep reports every address that is still live as a leak, one per cycle, then clears the table and raises a done flag.

The event input is valid/ready. The block accepts one event in every cycle in which `ev_ready` is high. `ev_ready` drops only while a sweep is running, so the trace source stalls only after it has signalled the end of its trace. While `ev_ready` is low the source must hold its event stable. The block never back-pressures in normal operation.

Top module: `apc_pair_checker`

## Requirements
- R1: A reserve event (opcode 0) for an address with no table slot takes the lowest-index empty slot as live and raises no violation; an address is never held by two slots at once.
- R2: A reserve event for an address that is live raises violation code 1 with that address and leaves the slot live.
- R3: A release event (opcode 1) for a live address moves it to released without a violation; a further release of that address raises code 2.
- R4: A release event for an address held by no slot raises code 3.
- R5: A reserve event when every slot holds a live address raises code 4 with the address, and that address is not tracked (a later release of it gives code 3).
- R6: When no slot is empty, a reserve event takes over the lowest-index released slot without a violation; the displaced address is then unknown, so releasing it gives code 3.
- R7: `ev_ready` is high whenever no sweep is running, and events on consecutive cycles each see the table as updated by the one before.
- R8: A violation appears on `viol_valid`/`viol_code`/`viol_addr` in the cycle after the event is accepted, for one cycle only.
- R9: A `trace_end` pulse while idle starts a sweep: `ev_ready` is low, each live address is reported once with code 5 in ascending slot order, one per cycle, then `sweep_done` rises and the table is empty (an empty table raises `sweep_done` one cycle after the sweep starts).
- R10: An event accepted in the same cycle as `trace_end` is applied before the sweep reads the table.
- R11: After reset `ev_ready` is 1, `viol_valid` is 0 and `sweep_done` is 0.
- R12: `sweep_done` stays high until the next accepted event or the next `trace_end`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event accepted this cycle if valid |
| ev_op | input | 1 | 0 = reserve, 1 = release |
| ev_addr | input | ADDR_W | Event address |
| trace_end | input | 1 | End-of-trace strobe, starts the leak sweep |
| viol_valid | output | 1 | Violation report present (one cycle) |
| viol_code | output | 3 | 1 double reserve, 2 double release, 3 unknown release, 4 table full, 5 leak |
| viol_addr | output | ADDR_W | Address of the violation |
| sweep_done | output | 1 | Sweep finished, table cleared |

## Verification
An event and the end-of-trace strobe can arrive in the same cycle. The bench provokes this by presenting a release of a live address together with `trace_end`. It then expects the leak reports to leave that address out, because the release has to be applied before the sweep reads the table. A second overlap is slot reclamation in the same cycle as a table-full condition. The bench fills every slot, releases one address and reserves a new one. It judges the result by the absence of a code 4 report and by a code 3 report when the displaced address is released again.

// File: rtl/apc_pkg.sv
package apc_pkg;
  typedef enum logic {
    OP_RESERVE = 1'b0,
    OP_RELEASE = 1'b1
  } apc_op_e;

  typedef enum logic [2:0] {
    VC_NONE          = 3'd0,
    VC_DOUBLE_RSV    = 3'd1,
    VC_DOUBLE_REL    = 3'd2,
    VC_UNKNOWN_REL   = 3'd3,
    VC_TABLE_FULL    = 3'd4,
    VC_LEAK          = 3'd5
  } apc_vcode_e;
endpackage

// File: rtl/apc_lookup.sv
module apc_lookup #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32
) (
  input  logic [ENTRIES-1:0]             slot_valid,
  input  logic [ENTRIES-1:0]             slot_live,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] slot_addr,
  input  logic [ADDR_W-1:0]              key,
  output logic [ENTRIES-1:0]             hit_live,
  output logic [ENTRIES-1:0]             hit_released,
  output logic [ENTRIES-1:0]             vacant,
  output logic [ENTRIES-1:0]             released
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic same;
    assign same            = slot_valid[g] && (slot_addr[g] == key);
    assign hit_live[g]     = same && slot_live[g];
    assign hit_released[g] = same && !slot_live[g];
    assign vacant[g]       = !slot_valid[g];
    assign released[g]     = slot_valid[g] && !slot_live[g];
  end
endmodule

// File: rtl/apc_prio_enc.sv
module apc_prio_enc #(
  parameter int WIDTH = 16,
  localparam int IW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] req,
  output logic             found,
  output logic [IW-1:0]    idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/apc_pair_checker.sv
module apc_pair_checker
  import apc_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic              ev_op,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              trace_end,
  output logic              viol_valid,
  output logic [2:0]        viol_code,
  output logic [ADDR_W-1:0] viol_addr,
  output logic              sweep_done
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]             slot_valid, slot_live;
  logic [ENTRIES-1:0][ADDR_W-1:0] slot_addr;
  logic                           sweeping;

  logic [ENTRIES-1:0] hit_live, hit_released, vacant, released;
  logic               hit_found, vac_found, rec_found, leak_found;
  logic [IW-1:0]      hit_idx, vac_idx, rec_idx, leak_idx;
  logic               accept, any_live_hit, any_rel_hit;

  assign ev_ready     = !sweeping;
  assign accept       = ev_valid && ev_ready;
  assign any_live_hit = |hit_live;
  assign any_rel_hit  = |hit_released;

  apc_lookup #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_lookup (
    .slot_valid  (slot_valid),
    .slot_live   (slot_live),
    .slot_addr   (slot_addr),
    .key         (ev_addr),
    .hit_live    (hit_live),
    .hit_released(hit_released),
    .vacant      (vacant),
    .released    (released)
  );

  apc_prio_enc #(.WIDTH(ENTRIES)) u_hit_enc (
    .req(hit_live | hit_released), .found(hit_found), .idx(hit_idx));
  apc_prio_enc #(.WIDTH(ENTRIES)) u_vac_enc (
    .req(vacant), .found(vac_found), .idx(vac_idx));
  apc_prio_enc #(.WIDTH(ENTRIES)) u_rec_enc (
    .req(released), .found(rec_found), .idx(rec_idx));
  apc_prio_enc #(.WIDTH(ENTRIES)) u_leak_enc (
    .req(slot_live), .found(leak_found), .idx(leak_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_valid <= '0;
      slot_live  <= '0;
      slot_addr  <= '0;
      sweeping   <= 1'b0;
      sweep_done <= 1'b0;
      viol_valid <= 1'b0;
      viol_code  <= VC_NONE;
      viol_addr  <= '0;
    end else begin
      viol_valid <= 1'b0;
      if (sweeping) begin
        if (leak_found) begin
          slot_valid[leak_idx] <= 1'b0;
          slot_live[leak_idx]  <= 1'b0;
          viol_valid           <= 1'b1;
          viol_code            <= VC_LEAK;
          viol_addr            <= slot_addr[leak_idx];
        end else begin
          slot_valid <= '0;
          slot_live  <= '0;
          sweeping   <= 1'b0;
          sweep_done <= 1'b1;
        end
      end else begin
        if (accept) begin
          sweep_done <= 1'b0;
          if (apc_op_e'(ev_op) == OP_RESERVE) begin
            if (any_live_hit) begin
              viol_valid <= 1'b1;
              viol_code  <= VC_DOUBLE_RSV;
              viol_addr  <= ev_addr;
            end else if (any_rel_hit && hit_found) begin
              slot_live[hit_idx] <= 1'b1;
            end else if (vac_found) begin
              slot_valid[vac_idx] <= 1'b1;
              slot_live[vac_idx]  <= 1'b1;
              slot_addr[vac_idx]  <= ev_addr;
            end else if (rec_found) begin
              slot_live[rec_idx] <= 1'b1;
              slot_addr[rec_idx] <= ev_addr;
            end else begin
              viol_valid <= 1'b1;
              viol_code  <= VC_TABLE_FULL;
              viol_addr  <= ev_addr;
            end
          end else begin
            if (any_live_hit && hit_found) begin
              slot_live[hit_idx] <= 1'b0;
            end else if (any_rel_hit) begin
              viol_valid <= 1'b1;
              viol_code  <= VC_DOUBLE_REL;
              viol_addr  <= ev_addr;
            end else begin
              viol_valid <= 1'b1;
              viol_code  <= VC_UNKNOWN_REL;
              viol_addr  <= ev_addr;
            end
          end
        end
        if (trace_end) begin
          sweeping   <= 1'b1;
          sweep_done <= 1'b0;
        end
      end
    end
  end

  // R1: at most one slot ever matches an address
  assert_unique_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $onehot0(hit_live | hit_released));

  // R2: a double-reserve report needs a live match on the accepted event
  assert_double_rsv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && viol_code == VC_DOUBLE_RSV) |-> $past(accept && any_live_hit));

  // R5: a full report only when every slot was live
  assert_table_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && viol_code == VC_TABLE_FULL) |-> $past(&slot_live));

  // R8: every report comes from an accepted event or a sweep step
  assert_viol_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> $past(accept || sweeping));

  // R9: a sweep starts only from the end strobe
  assert_sweep_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sweeping) |-> $past(trace_end));

  // R9: when the sweep has finished, nothing is live
  assert_done_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> (slot_live == '0));
endmodule

// File: tb/tb_apc_pair_checker.sv
module tb_apc_pair_checker;
  localparam int N  = 4;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ev_valid = 1'b0;
  logic          ev_ready;
  logic          ev_op = 1'b0;
  logic [AW-1:0] ev_addr = '0;
  logic          trace_end = 1'b0;
  logic          viol_valid;
  logic [2:0]    viol_code;
  logic [AW-1:0] viol_addr;
  logic          sweep_done;

  apc_pair_checker #(.ENTRIES(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_op(ev_op), .ev_addr(ev_addr), .trace_end(trace_end),
    .viol_valid(viol_valid), .viol_code(viol_code), .viol_addr(viol_addr),
    .sweep_done(sweep_done));

  always #5 clk = ~clk;

  typedef struct {
    logic [2:0]    code;
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;

  exp_t q[$];
  int compared = 0;
  int mismatched = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected reports as the design produces them
  always @(negedge clk) begin
    if (rst_n && viol_valid === 1'b1) begin
      if (q.size() == 0) begin
        compared++;
        mismatched++;
        $display("FAIL R8 unexpected report: actual code %0d addr %0h expected none",
                 viol_code, viol_addr);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(viol_code == e.code && viol_addr == e.addr, e.tag, "report code/addr",
              {viol_code, viol_addr}, {e.code, e.addr});
      end
    end
  end

  task automatic send(bit op, logic [AW-1:0] a, logic [2:0] code, string tag, bit with_end = 1'b0);
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    check(ev_ready == 1'b1, "R7", "ready while idle", ev_ready, 1);
    ev_valid  = 1'b1;
    ev_op     = op;
    ev_addr   = a;
    trace_end = with_end;
    @(posedge clk);
    #1;
    if (code != 3'd0) q.push_back('{code, a, tag});
    ev_valid  = 1'b0;
    trace_end = 1'b0;
  endtask

  task automatic end_trace();
    @(negedge clk);
    trace_end = 1'b1;
    @(posedge clk);
    #1;
    trace_end = 1'b0;
  endtask

  task automatic expect_leak(logic [AW-1:0] a);
    q.push_back('{3'd5, a, "R9"});
  endtask

  task automatic wait_done();
    for (int i = 0; i < 50 && !sweep_done; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(ev_ready == 1'b1,   "R11", "ready after reset", ev_ready, 1);
    check(viol_valid == 1'b0, "R11", "no report after reset", viol_valid, 0);
    check(sweep_done == 1'b0, "R11", "done after reset", sweep_done, 0);

    send(0, 16'h0100, 3'd0, "R1");
    send(0, 16'h0100, 3'd1, "R2");
    send(1, 16'h0100, 3'd0, "R3");
    send(1, 16'h0100, 3'd2, "R3");
    send(1, 16'h0222, 3'd3, "R4");
    send(0, 16'h0100, 3'd0, "R1");
    send(0, 16'h0201, 3'd0, "R1");
    send(0, 16'h0202, 3'd0, "R1");
    send(0, 16'h0203, 3'd0, "R1");
    send(0, 16'h0300, 3'd4, "R5");
    send(1, 16'h0300, 3'd3, "R5");
    send(1, 16'h0202, 3'd0, "R6");
    send(0, 16'h0400, 3'd0, "R6");
    send(1, 16'h0202, 3'd3, "R6");
    // back-to-back on one address, R7
    send(1, 16'h0201, 3'd0, "R7");
    send(0, 16'h0201, 3'd0, "R7");
    send(0, 16'h0201, 3'd1, "R7");

    // R10: release together with the end strobe; 0x203 must not leak
    send(1, 16'h0203, 3'd0, "R10", 1'b1);
    expect_leak(16'h0100);
    expect_leak(16'h0201);
    expect_leak(16'h0400);
    @(negedge clk);
    check(ev_ready == 1'b0, "R9", "ready during sweep", ev_ready, 0);
    wait_done();
    check(sweep_done == 1'b1, "R9", "done after sweep", sweep_done, 1);
    check(ev_ready == 1'b1, "R9", "ready after sweep", ev_ready, 1);
    check(q.size() == 0, "R10", "pending leak reports", q.size(), 0);

    repeat (3) @(negedge clk);
    check(sweep_done == 1'b1, "R12", "done held", sweep_done, 1);
    send(0, 16'h0100, 3'd0, "R12");
    @(negedge clk);
    check(sweep_done == 1'b0, "R12", "done cleared by event", sweep_done, 0);

    end_trace();
    expect_leak(16'h0100);
    wait_done();
    check(sweep_done == 1'b1, "R9", "done after single leak", sweep_done, 1);

    // empty table: done one cycle after the sweep starts
    end_trace();
    @(negedge clk);
    check(sweep_done == 1'b0, "R9", "done cleared at sweep start", sweep_done, 0);
    @(negedge clk);
    check(sweep_done == 1'b1, "R9", "empty sweep done", sweep_done, 1);

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R8", "reports left unseen", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule